// File: doc/BRIEF.md
# Folded Lifting Column Wavelet Engine

This block performs the vertical pass of a single-level (9,7) lifting wavelet transform on an image that arrives column by column. Each cycle it accepts one pair of vertically adjacent pixels (an even row sample and the odd row sample below it) together with the index of the column they belong to. Each cycle it returns one low-pass and one high-pass coefficient for that column. Every column carries four lifting state words from one pair to the next. Between visits to a column, these words are parked in a line buffer that holds one entry per column.

The parameter N (2 or 4) sets how many pairs of one column are fed back to back, forming a group. While a group is running, the state lives in local registers. The line buffer is read once as the group opens and written once after it closes. A single processing element therefore serves every cycle, and the line buffer can be a single-port memory with no cycle that both reads and writes it. A strip flag marks the first group of each column of an image, and those groups start from zero state.

Top module: `dwt_ml_col`

## Requirements
- R1: For each accepted pair (e, o) with column state (p, q, u, v), the block computes the following. A = e·a. d1 = p + A. s1 = q + d1·b. d2 = u + s1·g. s2 = v + d2·d. The new state is (o + A, e + d1·b, d1 + s1·g, s1 + d2·d). Each product x·c is (x·C + 2^(F-1)) >>> F, where C is the constant times 2^F rounded to the nearest integer (halves away from zero). The constants are a = -1.586134, b = -0.052980, g = 0.882911 and d = 0.443507.
- R2: For the pair accepted at a clock edge, the coefficients appear after the following edge with out_valid high. out_low is s2·K and out_high is d2·(1/K), with K = 1.149604, using the same rounding as R1. Exactly one output is produced per accepted pair.
- R3: Pairs arrive in groups of N consecutive in_valid cycles that share one in_col. Inside a group, each pair continues from the state left by the previous pair of that group.
- R4: The line buffer is read once per group, in the group's first input cycle, and written once per group with the group's final state. Each column's state therefore carries from one group of that column to the next, even when other columns come in between.
- R5: The line buffer is never read and written in the same cycle. A write that would collide with a read is moved to the following cycle, and the results stay correct.
- R6: A group whose first pair has in_top high starts from zero state and ignores any value stored for that column.
- R7: Idle cycles (in_valid low) between groups change no state and produce no output.
- R8: After reset, out_valid, out_low and out_high are 0.
- R9: All sums and rounded products wrap to W bits in two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pixel pair is presented this cycle |
| in_col | input | $clog2(COLS) | Column index of the pair |
| in_top | input | 1 | The group begins a fresh image strip (zero state) |
| in_even | input | W | Signed even-row sample |
| in_odd | input | W | Signed odd-row sample |
| out_valid | output | 1 | Coefficients valid |
| out_low | output | W | Signed low-pass coefficient |
| out_high | output | W | Signed high-pass coefficient |

## Verification
The bench replays whole small images through an exact integer model of the recursion. The columns are interleaved, so a design that restored the wrong column's state, or reused stale local registers at a group boundary, produces wrong coefficients. A one-cycle gap after each group forces the deferred write to land on the next group's read cycle. A design that dropped or misplaced that write would corrupt the state of the following strip. A second image reuses the same columns with the strip flag set, which exposes any leak of stored state. Samples near full scale expose a missing wrap at W bits.

// File: rtl/dwt_ml_pkg.sv
package dwt_ml_pkg;
   localparam real LIFT_A = -1.586134;
   localparam real LIFT_B = -0.052980;
   localparam real LIFT_G =  0.882911;
   localparam real LIFT_D =  0.443507;
   localparam real GAIN_K =  1.149604;

   // nearest integer to c * 2^f (SV real-to-int cast rounds half away from zero)
   function automatic int coef_q(real c, int f);
      return int'(c * (2.0 ** f));
   endfunction
endpackage

// File: rtl/dwt_ml_pe.sv
module dwt_ml_pe #(
   parameter int W = 16,
   parameter int F = 10
) (
   input  logic signed [W-1:0] e,
   input  logic signed [W-1:0] o,
   input  logic [4*W-1:0]      st_cur,
   output logic [4*W-1:0]      st_nxt,
   output logic signed [W-1:0] lo,
   output logic signed [W-1:0] hi
);
   import dwt_ml_pkg::*;

   localparam int QA  = coef_q(LIFT_A, F);
   localparam int QB  = coef_q(LIFT_B, F);
   localparam int QG  = coef_q(LIFT_G, F);
   localparam int QD  = coef_q(LIFT_D, F);
   localparam int QK  = coef_q(GAIN_K, F);
   localparam int QKI = coef_q(1.0 / GAIN_K, F);
   localparam int PW  = W + 32;
   localparam logic signed [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (F-1);

   function automatic logic signed [W-1:0] mulr(logic signed [W-1:0] x, int c);
      logic signed [PW-1:0] xe, ce, pr;
      xe = {{32{x[W-1]}}, x};
      ce = {{W{c[31]}}, c};
      pr = (xe * ce + HALF) >>> F;
      return pr[W-1:0];
   endfunction

   logic signed [W-1:0] p, q, u, v;
   logic signed [W-1:0] pa, pb, pg, pd, d1, s1, d2, s2;

   assign p = st_cur[0*W +: W];
   assign q = st_cur[1*W +: W];
   assign u = st_cur[2*W +: W];
   assign v = st_cur[3*W +: W];

   always_comb begin
      pa = mulr(e, QA);
      d1 = p + pa;
      pb = mulr(d1, QB);
      s1 = q + pb;
      pg = mulr(s1, QG);
      d2 = u + pg;
      pd = mulr(d2, QD);
      s2 = v + pd;
      lo = mulr(s2, QK);
      hi = mulr(d2, QKI);
   end

   assign st_nxt = {s1 + pd, d1 + pg, e + pb, o + pa};
endmodule

// File: rtl/dwt_ml_spram.sv
module dwt_ml_spram #(
   parameter int DEPTH = 8,
   parameter int DW    = 64
) (
   input  logic                     clk,
   input  logic                     en,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [DW-1:0]            wdata,
   output logic [DW-1:0]            rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/dwt_ml_fold.sv
module dwt_ml_fold #(
   parameter int W  = 16,
   parameter int CW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pe_v,
   input  logic            pe_first,
   input  logic            pe_last,
   input  logic            pe_top,
   input  logic [CW-1:0]   pe_col,
   input  logic [4*W-1:0]  rd_data,
   input  logic            rd_busy,
   input  logic [4*W-1:0]  nxt,
   output logic [4*W-1:0]  cur,
   output logic            wr_en,
   output logic [CW-1:0]   wr_col,
   output logic [4*W-1:0]  wr_data
);
   logic [4*W-1:0] st_q;
   logic           pend;

   always_comb begin
      if (pe_first) cur = pe_top ? '0 : rd_data;
      else          cur = st_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         pend   <= 1'b0;
         wr_col <= '0;
      end else begin
         if (pe_v) st_q <= nxt;
         if (pe_v && pe_last) begin
            pend   <= 1'b1;
            wr_col <= pe_col;
         end else if (wr_en) begin
            pend <= 1'b0;
         end
      end
   end

   assign wr_en   = pend && !rd_busy;
   assign wr_data = st_q;

   // R7: idle cycles leave the folded state untouched
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pe_v |=> $stable(st_q));
   // R5: a write displaced by a read is issued on the very next cycle
   a_r5_defer_once: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && rd_busy && !(pe_v && pe_last)) |=> wr_en);
endmodule

// File: rtl/dwt_ml_col.sv
module dwt_ml_col #(
   parameter int N    = 2,
   parameter int COLS = 8,
   parameter int W    = 16,
   parameter int F    = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [$clog2(COLS)-1:0]   in_col,
   input  logic                      in_top,
   input  logic signed [W-1:0]       in_even,
   input  logic signed [W-1:0]       in_odd,
   output logic                      out_valid,
   output logic signed [W-1:0]       out_low,
   output logic signed [W-1:0]       out_high
);
   localparam int CW = $clog2(COLS);
   localparam int PH = $clog2(N);
   localparam int SW = 4 * W;

   if (N != 2 && N != 4) begin : g_bad_n
      $error("group length N must be 2 or 4");
   end
   if (F < 1 || F >= W) begin : g_bad_f
      $error("fraction bits F must lie in 1..W-1");
   end

   logic [PH-1:0]       ph_q;
   logic                ram_re;
   logic                pe_v, pe_top;
   logic [PH-1:0]       pe_ph;
   logic [CW-1:0]       pe_col;
   logic signed [W-1:0] pe_e, pe_o;
   logic [SW-1:0]       st_cur, st_nxt, rd_data, wr_data;
   logic                wr_en;
   logic [CW-1:0]       wr_col;
   logic signed [W-1:0] lo, hi;
   logic                pe_first, pe_last;

   // group phase counter: variant picked by N
   if ((N & (N - 1)) == 0) begin : g_ph_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ph_q <= '0;
         else if (in_valid) ph_q <= ph_q + 1'b1;
      end
   end else begin : g_ph_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ph_q <= '0;
         else if (in_valid) ph_q <= (ph_q == PH'(N-1)) ? '0 : ph_q + 1'b1;
      end
   end

   assign ram_re = in_valid && (ph_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pe_v   <= 1'b0;
         pe_top <= 1'b0;
         pe_ph  <= '0;
         pe_col <= '0;
         pe_e   <= '0;
         pe_o   <= '0;
      end else begin
         pe_v <= in_valid;
         if (in_valid) begin
            pe_ph  <= ph_q;
            pe_col <= in_col;
            pe_e   <= in_even;
            pe_o   <= in_odd;
            if (ph_q == '0) pe_top <= in_top;
         end
      end
   end

   assign pe_first = (pe_ph == '0);
   assign pe_last  = (pe_ph == PH'(N-1));

   dwt_ml_spram #(.DEPTH(COLS), .DW(SW)) u_buf (
      .clk   (clk),
      .en    (ram_re || wr_en),
      .we    (wr_en),
      .addr  (wr_en ? wr_col : in_col),
      .wdata (wr_data),
      .rdata (rd_data)
   );

   dwt_ml_fold #(.W(W), .CW(CW)) u_fold (
      .clk      (clk),
      .rst_n    (rst_n),
      .pe_v     (pe_v),
      .pe_first (pe_first),
      .pe_last  (pe_last),
      .pe_top   (pe_top),
      .pe_col   (pe_col),
      .rd_data  (rd_data),
      .rd_busy  (ram_re),
      .nxt      (st_nxt),
      .cur      (st_cur),
      .wr_en    (wr_en),
      .wr_col   (wr_col),
      .wr_data  (wr_data)
   );

   dwt_ml_pe #(.W(W), .F(F)) u_pe (
      .e      (pe_e),
      .o      (pe_o),
      .st_cur (st_cur),
      .st_nxt (st_nxt),
      .lo     (lo),
      .hi     (hi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_low   <= '0;
         out_high  <= '0;
      end else begin
         out_valid <= pe_v;
         if (pe_v) begin
            out_low  <= lo;
            out_high <= hi;
         end
      end
   end

   // R5: one access per cycle on the line buffer
   a_r5_single_port: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_re && wr_en));
   // R4: the buffer read is consumed by the first step of a group
   a_r4_read_feeds_group: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |=> (pe_v && pe_first));
   // R2: every processed pair yields one output
   a_r2_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pe_v |=> out_valid);
   // R3: all pairs of a group belong to one column
   a_r3_group_column: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_v && !pe_first) |-> (pe_col == $past(pe_col)));
endmodule

// File: tb/sim_dwt_ml_col.sv
module sim_dwt_ml_col;
   localparam int N    = 2;
   localparam int COLS = 8;
   localparam int W    = 16;
   localparam int F    = 10;
   localparam int CW   = $clog2(COLS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [CW-1:0] in_col = '0;
   logic in_top = 1'b0;
   logic signed [W-1:0] in_even = '0, in_odd = '0;
   logic out_valid;
   logic signed [W-1:0] out_low, out_high;

   always #10 clk = ~clk;

   dwt_ml_col #(.N(N), .COLS(COLS), .W(W), .F(F)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
      .in_top(in_top), .in_even(in_even), .in_odd(in_odd),
      .out_valid(out_valid), .out_low(out_low), .out_high(out_high));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   function automatic longint qc(real c);
      real s;
      s = c * 1024.0;
      return longint'($rtoi(s >= 0.0 ? s + 0.5 : s - 0.5));
   endfunction

   longint KA, KB, KG, KD, KK, KKI;

   function automatic longint wr(longint x);
      logic signed [W-1:0] t;
      t = x[W-1:0];
      return longint'(t);
   endfunction

   function automatic longint rm(longint x, longint c);
      return wr((x * c + 512) >>> F);
   endfunction

   longint gp[COLS], gq[COLS], gu[COLS], gv[COLS];
   longint exp_lo[1024], exp_hi[1024];
   string  exp_tag[1024];
   int wr_i = 0, rd_i = 0;

   task automatic chk(bit ok, string tag, longint act, longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // drive one pair at a falling edge, model it, return at the next falling edge
   task automatic send(int col, int k, bit top, longint e, longint o, string tag);
      longint p, q, u, v, a, d1, s1, d2, s2, mb, mg, md;
      in_valid = 1'b1; in_col = CW'(col); in_top = top;
      in_even = W'(e); in_odd = W'(o);
      if (k == 0 && top) begin gp[col] = 0; gq[col] = 0; gu[col] = 0; gv[col] = 0; end
      p = gp[col]; q = gq[col]; u = gu[col]; v = gv[col];
      a  = rm(e, KA);
      d1 = wr(p + a);   mb = rm(d1, KB);
      s1 = wr(q + mb);  mg = rm(s1, KG);
      d2 = wr(u + mg);  md = rm(d2, KD);
      s2 = wr(v + md);
      gp[col] = wr(o + a); gq[col] = wr(e + mb);
      gu[col] = wr(d1 + mg); gv[col] = wr(s1 + md);
      exp_lo[wr_i] = rm(s2, KK); exp_hi[wr_i] = rm(d2, KKI); exp_tag[wr_i] = tag;
      wr_i++;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   function automatic longint pix(int pat, int r, int c);
      case (pat)
         0: return longint'((r * 16 + c * 3) % 256);
         1: return longint'(((r * 37) ^ (c * 91 + 13)) % 256);
         2: return ((r + c) % 2 == 0) ? 32000 : -32000;
         default: return 128;
      endcase
   endfunction

   task automatic image(int ncol, int strips, int pat, int gap, string tag);
      for (int s = 0; s < strips; s++)
         for (int c = 0; c < ncol; c++) begin
            for (int k = 0; k < N; k++)
               send(c, k, s == 0, pix(pat, s*2*N + 2*k, c), pix(pat, s*2*N + 2*k + 1, c), tag);
            if (gap > 0) idle(gap);
         end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid && !finished) begin
         if (rd_i < wr_i) begin
            chk(longint'(out_low) == exp_lo[rd_i], {exp_tag[rd_i], " low"}, out_low, exp_lo[rd_i]);
            chk(longint'(out_high) == exp_hi[rd_i], {exp_tag[rd_i], " high"}, out_high, exp_hi[rd_i]);
         end else begin
            chk(1'b0, "R7 R2 spurious output", rd_i, wr_i);
         end
         rd_i++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      KA = qc(-1.586134); KB = qc(-0.052980); KG = qc(0.882911);
      KD = qc(0.443507);  KK = qc(1.149604);  KKI = qc(1.0 / 1.149604);
      repeat (3) @(negedge clk);
      // R8: reset values
      chk(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
      chk(out_low == 0, "R8 out_low", out_low, 0);
      chk(out_high == 0, "R8 out_high", out_high, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: latency of the very first pair
      send(0, 0, 1'b1, 100, 50, "R2 R6 first");
      chk(out_valid == 1'b0, "R2 not yet valid", out_valid, 0);
      send(0, 1, 1'b1, 90, 40, "R2 R3 first");
      chk(out_valid == 1'b1, "R2 valid after two edges", out_valid, 1);
      idle(3);
      // R1 R3 R4: ramp image, columns interleaved, back to back groups
      image(4, 4, 0, 0, "R1 R3 R4");
      // R6: fresh image on same columns must ignore stored state
      image(COLS, 3, 1, 0, "R6 R4");
      // R5 R7: one-cycle gaps push each write onto the next read slot
      image(5, 4, 1, 1, "R5 R7");
      // R7: long idle between groups
      image(3, 3, 3, 4, "R7 idle");
      // R9: full-scale samples overflow and wrap
      image(4, 3, 2, 0, "R9 wrap");
      idle(5);
      chk(rd_i == wr_i, "R2 output count", rd_i, wr_i);
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule